// File: doc/BRIEF.md
# Counted Loop Branch Controller

This block decides the outcome of counted loop-closing branches and updates the two counters behind them. An iteration counter gives the number of trips still to run through the loop body. A drain counter gives the number of extra trips needed to empty a software-pipelined loop once the iteration counter has run out. Each counter is loaded from its own port.

Each branch request names one of two forms. The simple form only looks at the iteration counter. The pipelined form also drives a rotate pulse to the register rename unit, and it gives the value to write into the highest rotating stage predicate. A 1 in that predicate starts a new source iteration. A 0 lets the pipeline drain.

Results are registered. A request in one cycle shows its outcome in the next cycle, and the counters take their new values on the same edge. A counter load in the same cycle as a request is applied first, so the request acts on the loaded value.

Top module: `loop_branch_ctl`

## Requirements
- R1: After reset both counters read 0 and res_valid_o, res_taken_o, rot_o, stage_pred_we_o and stage_pred_o are all 0.
- R2: A load strobe (iter_ld_i or drain_ld_i) writes its value port into that counter. The new value is visible on iter_cnt_o or drain_cnt_o in the next cycle.
- R3: A request (br_req_i=1) gives res_valid_o=1 for exactly the next cycle. A cycle with no request gives all result outputs 0 in the next cycle.
- R4: In the simple form (br_pipe_i=0) with a nonzero iteration counter, the branch is taken and the iteration counter drops by one. There is no rotation and no predicate write, and the drain counter is unchanged.
- R5: In the simple form with the iteration counter at 0, the branch falls through. There is no rotation and no predicate write, and both counters are unchanged.
- R6: In the pipelined form (br_pipe_i=1) with a nonzero iteration counter, the iteration counter drops by one and the drain counter is unchanged. The block writes 1 to the stage predicate, pulses rot_o and takes the branch.
- R7: In the pipelined form with the iteration counter at 0 and the drain counter above 1, the drain counter drops by one. The block writes 0 to the stage predicate, pulses rot_o and takes the branch.
- R8: In the pipelined form with the iteration counter at 0 and the drain counter at 1 or 0, the drain counter becomes 0, staying at 0 rather than wrapping. The block writes 0 to the stage predicate and pulses rot_o, and the branch falls through.
- R9: When a load and a request happen in the same cycle, the request is decided on the loaded value.
- R10: In the pipelined form, with counters loaded as N and E (E at least 1), N+E requests follow. All but the last are taken, and every one of them rotates. Loads of 3/4 and of 3/11 end with both counters at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iter_ld_i | input | 1 | Load the iteration counter |
| iter_val_i | input | CNT_W | Value for the iteration counter |
| drain_ld_i | input | 1 | Load the drain counter |
| drain_val_i | input | DRN_W | Value for the drain counter |
| br_req_i | input | 1 | Branch request |
| br_pipe_i | input | 1 | Branch form: 0 simple, 1 pipelined |
| res_valid_o | output | 1 | Result valid, one cycle after a request |
| res_taken_o | output | 1 | 1 taken, 0 fall-through |
| rot_o | output | 1 | One-cycle rotate pulse for the rename unit |
| stage_pred_we_o | output | 1 | Write enable for the top rotating predicate |
| stage_pred_o | output | 1 | Value to write into the top rotating predicate |
| iter_cnt_o | output | CNT_W | Current iteration counter |
| drain_cnt_o | output | DRN_W | Current drain counter |

## Verification
A counter load and a branch request can happen in the same cycle, and the request must then act on the freshly loaded value rather than the stale one.

The bench provokes this in two ways:
- It raises both strobes on the same cycle with a stale count of 0 and a new count of 2. The outcome has to be taken, and the counter has to read 1.
- It reloads the drain counter to 1 while a pipelined request arrives with a stale drain value of 5. The branch has to fall through, leaving the counter at 0.

// File: rtl/loop_branch_ctl.sv
module loop_branch_ctl #(
  parameter int CNT_W = 16,
  parameter int DRN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iter_ld_i,
  input  logic [CNT_W-1:0] iter_val_i,
  input  logic             drain_ld_i,
  input  logic [DRN_W-1:0] drain_val_i,
  input  logic             br_req_i,
  input  logic             br_pipe_i,
  output logic             res_valid_o,
  output logic             res_taken_o,
  output logic             rot_o,
  output logic             stage_pred_we_o,
  output logic             stage_pred_o,
  output logic [CNT_W-1:0] iter_cnt_o,
  output logic [DRN_W-1:0] drain_cnt_o
);

  logic [CNT_W-1:0] iter_q, iter_eff, iter_nx;
  logic [DRN_W-1:0] drain_q, drain_eff, drain_nx;
  logic taken_nx, rot_nx, we_nx, pred_nx;

  // loads are applied before the request is evaluated
  assign iter_eff  = iter_ld_i  ? iter_val_i  : iter_q;
  assign drain_eff = drain_ld_i ? drain_val_i : drain_q;

  always_comb begin
    iter_nx  = iter_eff;
    drain_nx = drain_eff;
    taken_nx = 1'b0;
    rot_nx   = 1'b0;
    we_nx    = 1'b0;
    pred_nx  = 1'b0;
    if (br_req_i) begin
      if (iter_eff != '0) begin
        iter_nx  = iter_eff - CNT_W'(1);
        taken_nx = 1'b1;
        rot_nx   = br_pipe_i;
        we_nx    = br_pipe_i;
        pred_nx  = br_pipe_i;
      end else if (br_pipe_i) begin
        rot_nx   = 1'b1;
        we_nx    = 1'b1;
        taken_nx = (drain_eff > DRN_W'(1));
        if (drain_eff != '0) drain_nx = drain_eff - DRN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_q          <= '0;
      drain_q         <= '0;
      res_valid_o     <= 1'b0;
      res_taken_o     <= 1'b0;
      rot_o           <= 1'b0;
      stage_pred_we_o <= 1'b0;
      stage_pred_o    <= 1'b0;
    end else begin
      iter_q          <= iter_nx;
      drain_q         <= drain_nx;
      res_valid_o     <= br_req_i;
      res_taken_o     <= taken_nx;
      rot_o           <= rot_nx;
      stage_pred_we_o <= we_nx;
      stage_pred_o    <= pred_nx;
    end
  end

  assign iter_cnt_o  = iter_q;
  assign drain_cnt_o = drain_q;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    br_req_i |=> res_valid_o); // R3
  AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !br_req_i |=> !res_valid_o && !rot_o && !stage_pred_we_o && !res_taken_o); // R3
  AST_ITER_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req_i && !iter_ld_i && iter_cnt_o != '0) |=> iter_cnt_o == $past(iter_cnt_o) - CNT_W'(1)); // R4
  AST_SIMPLE_NO_ROT: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req_i && !br_pipe_i) |=> !rot_o && !stage_pred_we_o); // R5
  AST_SIMPLE_DRAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req_i && !br_pipe_i && !drain_ld_i) |=> $stable(drain_cnt_o)); // R4
  AST_PIPE_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req_i && br_pipe_i) |=> rot_o && stage_pred_we_o); // R6
  AST_PRED_SET_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    stage_pred_o |-> res_taken_o && rot_o && stage_pred_we_o); // R6
  AST_FALL_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_o && !res_taken_o) |-> drain_cnt_o == '0 && !stage_pred_o); // R8

endmodule

// File: tb/loop_branch_ctl_tb.sv
module loop_branch_ctl_tb_top;
  localparam int CLK_P = 10;
  localparam int CW = 16;
  localparam int DW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iter_ld = 0, drain_ld = 0, br_req = 0, br_pipe = 0;
  logic [CW-1:0] iter_val = '0;
  logic [DW-1:0] drain_val = '0;
  logic res_valid, res_taken, rot, pwe, pval;
  logic [CW-1:0] iter_cnt;
  logic [DW-1:0] drain_cnt;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  loop_branch_ctl #(.CNT_W(CW), .DRN_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .iter_ld_i(iter_ld), .iter_val_i(iter_val),
    .drain_ld_i(drain_ld), .drain_val_i(drain_val),
    .br_req_i(br_req), .br_pipe_i(br_pipe),
    .res_valid_o(res_valid), .res_taken_o(res_taken), .rot_o(rot),
    .stage_pred_we_o(pwe), .stage_pred_o(pval),
    .iter_cnt_o(iter_cnt), .drain_cnt_o(drain_cnt));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // result vector {valid,taken,rot,we,pred}
  function automatic int res_vec();
    return {27'd0, res_valid, res_taken, rot, pwe, pval};
  endfunction

  task automatic load(input int n, input int e);
    @(negedge clk);
    iter_ld = 1; iter_val = CW'(n); drain_ld = 1; drain_val = DW'(e);
    @(negedge clk);
    iter_ld = 0; drain_ld = 0;
  endtask

  task automatic request(input logic pipe);
    @(negedge clk);
    br_req = 1; br_pipe = pipe;
    @(negedge clk);
    br_req = 0;
  endtask

  task automatic t_reset;
    check("R1 results", res_vec(), 0);
    check("R1 iter", int'(iter_cnt), 0);
    check("R1 drain", int'(drain_cnt), 0);
  endtask

  task automatic t_load;
    load(37, 9);
    check("R2 iter load", int'(iter_cnt), 37);
    check("R2 drain load", int'(drain_cnt), 9);
    @(negedge clk);
    check("R3 idle results", res_vec(), 0);
  endtask

  task automatic t_simple;
    load(2, 5);
    request(0);
    check("R4 taken vec", res_vec(), 5'b11000);
    check("R4 iter", int'(iter_cnt), 1);
    check("R4 drain", int'(drain_cnt), 5);
    request(0);
    check("R4 second iter", int'(iter_cnt), 0);
    request(0);
    check("R5 fall vec", res_vec(), 5'b10000);
    check("R5 iter", int'(iter_cnt), 0);
    check("R5 drain", int'(drain_cnt), 5);
    @(negedge clk);
    check("R3 pulse ends", res_vec(), 0);
  endtask

  task automatic t_pipe_cases;
    load(1, 3);
    request(1);
    check("R6 vec", res_vec(), 5'b11111);
    check("R6 iter", int'(iter_cnt), 0);
    check("R6 drain", int'(drain_cnt), 3);
    request(1);
    check("R7 vec", res_vec(), 5'b11110);
    check("R7 drain", int'(drain_cnt), 2);
    request(1);
    check("R7 vec2", res_vec(), 5'b11110);
    request(1);
    check("R8 vec", res_vec(), 5'b10110);
    check("R8 drain", int'(drain_cnt), 0);
    request(1);
    check("R8 saturate vec", res_vec(), 5'b10110);
    check("R8 saturate drain", int'(drain_cnt), 0);
  endtask

  task automatic t_same_cycle;
    load(0, 5);
    @(negedge clk);
    iter_ld = 1; iter_val = 2; br_req = 1; br_pipe = 0;
    @(negedge clk);
    iter_ld = 0; br_req = 0;
    check("R9 taken on loaded", res_vec(), 5'b11000);
    check("R9 iter", int'(iter_cnt), 1);
    load(0, 5);
    @(negedge clk);
    drain_ld = 1; drain_val = 1; br_req = 1; br_pipe = 1;
    @(negedge clk);
    drain_ld = 0; br_req = 0;
    check("R9 fall on loaded", res_vec(), 5'b10110);
    check("R9 drain", int'(drain_cnt), 0);
  endtask

  task automatic t_sequence(input int n, input int e);
    int taken = 0, rots = 0, reqs = 0, preds = 0;
    load(n, e);
    for (int k = 0; k < 64; k++) begin
      request(1);
      reqs++;
      if (rot) rots++;
      if (pval) preds++;
      if (!res_taken) break;
      taken++;
    end
    check("R10 requests", reqs, n + e);
    check("R10 taken", taken, n + e - 1);
    check("R10 rotations", rots, n + e);
    check("R10 predicate ones", preds, n);
    check("R10 iter end", int'(iter_cnt), 0);
    check("R10 drain end", int'(drain_cnt), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_simple();
    t_pipe_cases();
    t_same_cycle();
    t_sequence(3, 4);
    t_sequence(3, 11);
    t_sequence(0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule